// File: doc/BRIEF.md
# AXI Inter-Channel Latency Watchdog

This block sits beside one AXI4 connection and watches it without driving anything. It times how long the link stays idle between events that belong together on different channels. The gaps it times are read address to read data, write address to write data, write data ahead of its address, and a finished write to its response. When a gap goes past its limit, it raises a sticky error flag for that check. It also tracks how many reads and writes still owe a completion, so each timer runs only while something is outstanding. Data values, IDs and ordering across IDs are out of scope.

Integrators set one idle-cycle limit per check, where zero removes that check entirely. They also set the read and write tracking depths to at least the largest number of transactions the connection can have outstanding. The error vector and a one-cycle first-failure pulse can feed an interrupt, a debug capture or a simulation monitor. Reset is synchronous and active high.

Top module: `axi_gap_watchdog`

## Requirements
- R1: While `rst` is high at a clock edge, `err_flags` clears to all zero and `err_pulse` to 0 after that edge. This also clears flags that were set before.
- R2: After an accepted AR handshake, each clock edge with a read outstanding and `rvalid` low is one idle cycle. Idle cycles numbered 1 to `R_AFTER_AR_MAX` are allowed. Idle cycle number `R_AFTER_AR_MAX`+1 sets `err_flags[0]` at that edge.
- R3: While more AW handshakes than WLAST beats have been accepted, each edge with `wvalid` low is idle. Idle cycle number `W_AFTER_AW_MAX`+1 sets `err_flags[1]`.
- R4: While more WLAST beats than AW handshakes have been accepted (write data ahead of its address), each edge with `awvalid` low is idle. Idle cycle number `AW_AFTER_WLAST_MAX`+1 sets `err_flags[2]`.
- R5: A write is complete once both its AW handshake and its WLAST beat have been accepted. While any complete write awaits a B handshake, each edge with `bvalid` low is idle. Idle cycle number `B_AFTER_WEND_MAX`+1 sets `err_flags[3]`.
- R6: An idle count returns to zero on any edge where the awaited valid is high. Idle runs separated by a valid cycle, such as the gaps between beats of one read burst, never add up.
- R7: A read stops being outstanding when a beat with `rvalid`, `rready` and `rlast` all high is accepted. Once every read has completed, idle cycles of any length set no flag.
- R8: The read tracker holds up to `RD_DEPTH` outstanding reads. An AR handshake while it is full, with no completing beat in the same cycle, sets `err_flags[4]`.
- R9: The write tracker holds up to `WR_DEPTH` complete writes awaiting B. It frees one entry on each B handshake. A write completing while the tracker is full, with no B in the same cycle, sets `err_flags[5]`.
- R10: A limit parameter of 0 disables its timing check. That flag never sets, however long the gap.
- R11: Every flag stays set until reset. `err_pulse` is high for exactly one cycle, on the edge where the first flag after reset sets. Later failures do not pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arvalid | input | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rvalid | input | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rlast | input | 1 | Last beat of read burst |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wlast | input | 1 | Last beat of write burst |
| bvalid | input | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| err_flags | output | 6 | Sticky flags: 0 read data late, 1 write data late, 2 write address late, 3 write response late, 4 read tracker overflow, 5 write tracker overflow |
| err_pulse | output | 1 | One-cycle pulse on the first failure after reset |

## Verification
The hardest state to reach from the ports is on the write side, where address and data may arrive in either order. Write data that runs ahead of its address must start the address timer and stop the data timer. A write counts as complete only when both halves have arrived, and only then does it enter the response tracker. The stimulus drives WLAST beats with no matching address, then supplies the address late. To fill the response tracker to overflow without setting off the response timer, it issues address and last data in the same cycle over consecutive cycles. A second instance with every limit at zero sees the same long stalls to show the disabled checks stay silent.

// File: rtl/axi_gap_pkg.sv
package axi_gap_pkg;
  localparam int NCHK        = 6;
  localparam int CHK_R_LATE  = 0;
  localparam int CHK_W_LATE  = 1;
  localparam int CHK_AW_LATE = 2;
  localparam int CHK_B_LATE  = 3;
  localparam int CHK_RD_OVF  = 4;
  localparam int CHK_WR_OVF  = 5;
endpackage

// File: rtl/owed_queue.sv
// Occupancy tracker for transactions that still owe a completion.
module owed_queue #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  output logic nonempty,
  output logic ovf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;
  logic full, pop_ok, push_ok;

  assign full     = (cnt_q == CW'(DEPTH));
  assign pop_ok   = pop && (cnt_q != '0);
  assign push_ok  = push && (!full || pop_ok);
  assign ovf      = push && !push_ok;
  assign nonempty = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push_ok && !pop_ok) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/gap_timer.sv
// Counts consecutive idle cycles; LIMIT of zero removes the timer.
module gap_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  output logic late
);
  generate
    if (LIMIT == 0) begin : g_off
      logic unused_tmr;
      assign unused_tmr = &{1'b0, clk, rst, pending};
      assign late = 1'b0;
    end else begin : g_on
      localparam int CW = $clog2(LIMIT + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || !pending) begin
          cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign late = pending && (cnt_q == CW'(LIMIT));
    end
  endgenerate
endmodule

// File: rtl/axi_gap_watchdog.sv
module axi_gap_watchdog
  import axi_gap_pkg::*;
#(
  parameter int RD_DEPTH           = 4,
  parameter int WR_DEPTH           = 4,
  parameter int R_AFTER_AR_MAX     = 16,
  parameter int W_AFTER_AW_MAX     = 16,
  parameter int AW_AFTER_WLAST_MAX = 16,
  parameter int B_AFTER_WEND_MAX   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arvalid,
  input  logic            arready,
  input  logic            rvalid,
  input  logic            rready,
  input  logic            rlast,
  input  logic            awvalid,
  input  logic            awready,
  input  logic            wvalid,
  input  logic            wready,
  input  logic            wlast,
  input  logic            bvalid,
  input  logic            bready,
  output logic [NCHK-1:0] err_flags,
  output logic            err_pulse
);
  localparam int BW = $clog2(WR_DEPTH + 1) + 2;

  logic ar_hs, rl_hs, aw_hs, wl_hs, b_hs;
  assign ar_hs = arvalid && arready;
  assign rl_hs = rvalid && rready && rlast;
  assign aw_hs = awvalid && awready;
  assign wl_hs = wvalid && wready && wlast;
  assign b_hs  = bvalid && bready;

  // Read side
  logic rd_nonempty, rd_ovf;
  owed_queue #(.DEPTH(RD_DEPTH)) u_rdq (
    .clk(clk), .rst(rst), .push(ar_hs), .pop(rl_hs),
    .nonempty(rd_nonempty), .ovf(rd_ovf)
  );

  // Write side: signed balance of addresses against last data beats
  logic signed [BW-1:0] wr_bal_q;
  logic wr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bal_q <= '0;
    end else if (aw_hs && !wl_hs) begin
      wr_bal_q <= wr_bal_q + BW'(1);
    end else if (wl_hs && !aw_hs) begin
      wr_bal_q <= wr_bal_q - BW'(1);
    end
  end

  assign wr_done = (aw_hs && wl_hs) ||
                   (aw_hs && (wr_bal_q < 0)) ||
                   (wl_hs && (wr_bal_q > 0));

  logic wr_nonempty, wr_ovf;
  owed_queue #(.DEPTH(WR_DEPTH)) u_wrq (
    .clk(clk), .rst(rst), .push(wr_done), .pop(b_hs),
    .nonempty(wr_nonempty), .ovf(wr_ovf)
  );

  // Idle-gap timers
  logic idle_r, idle_w, idle_aw, idle_b;
  logic late_r, late_w, late_aw, late_b;

  assign idle_r  = rd_nonempty && !rvalid;
  assign idle_w  = (wr_bal_q > 0) && !wvalid;
  assign idle_aw = (wr_bal_q < 0) && !awvalid;
  assign idle_b  = wr_nonempty && !bvalid;

  gap_timer #(.LIMIT(R_AFTER_AR_MAX)) u_t_r (
    .clk(clk), .rst(rst), .pending(idle_r), .late(late_r)
  );
  gap_timer #(.LIMIT(W_AFTER_AW_MAX)) u_t_w (
    .clk(clk), .rst(rst), .pending(idle_w), .late(late_w)
  );
  gap_timer #(.LIMIT(AW_AFTER_WLAST_MAX)) u_t_aw (
    .clk(clk), .rst(rst), .pending(idle_aw), .late(late_aw)
  );
  gap_timer #(.LIMIT(B_AFTER_WEND_MAX)) u_t_b (
    .clk(clk), .rst(rst), .pending(idle_b), .late(late_b)
  );

  // Error collection
  logic [NCHK-1:0] events;
  always_comb begin
    events              = '0;
    events[CHK_R_LATE]  = late_r;
    events[CHK_W_LATE]  = late_w;
    events[CHK_AW_LATE] = late_aw;
    events[CHK_B_LATE]  = late_b;
    events[CHK_RD_OVF]  = rd_ovf;
    events[CHK_WR_OVF]  = wr_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_flags <= err_flags | events;
      err_pulse <= (|events) && (err_flags == '0);
    end
  end
endmodule

// File: rtl/axi_gap_watchdog_chk.sv
module axi_gap_watchdog_chk
  import axi_gap_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            arvalid,
  input logic            arready,
  input logic            rvalid,
  input logic            awvalid,
  input logic            awready,
  input logic            wvalid,
  input logic            wready,
  input logic            wlast,
  input logic            bvalid,
  input logic [NCHK-1:0] err_flags,
  input logic            err_pulse
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (err_flags == '0) && !err_pulse);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  a_r11_pulse_first: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_flags != '0) && ($past(err_flags) == '0));

  a_r11_pulse_single: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);

  a_r2_r_late_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flags[CHK_R_LATE]) |-> $past(!rvalid));

  a_r3_w_late_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flags[CHK_W_LATE]) |-> $past(!wvalid));

  a_r4_aw_late_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flags[CHK_AW_LATE]) |-> $past(!awvalid));

  a_r5_b_late_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flags[CHK_B_LATE]) |-> $past(!bvalid));

  a_r8_rd_ovf_on_push: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flags[CHK_RD_OVF]) |-> $past(arvalid && arready));

  a_r9_wr_ovf_on_push: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flags[CHK_WR_OVF]) |-> $past((awvalid && awready) || (wvalid && wready && wlast)));
endmodule

bind axi_gap_watchdog axi_gap_watchdog_chk u_chk (
  .clk(clk), .rst(rst), .arvalid(arvalid), .arready(arready), .rvalid(rvalid),
  .awvalid(awvalid), .awready(awready), .wvalid(wvalid), .wready(wready),
  .wlast(wlast), .bvalid(bvalid), .err_flags(err_flags), .err_pulse(err_pulse)
);

// File: tb/sim_axi_gap_watchdog.sv
`timescale 1ns/1ps
module sim_axi_gap_watchdog;
  localparam int LR = 5, LW = 6, LAW = 7, LB = 8, DEP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arvalid = 0, arready = 0, rvalid = 0, rready = 0, rlast = 0;
  logic awvalid = 0, awready = 0, wvalid = 0, wready = 0, wlast = 0;
  logic bvalid = 0, bready = 0;
  logic [5:0] f0, f1;
  logic p0, p1;
  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;

  always #4 clk = ~clk;

  axi_gap_watchdog #(.RD_DEPTH(DEP), .WR_DEPTH(DEP), .R_AFTER_AR_MAX(LR),
    .W_AFTER_AW_MAX(LW), .AW_AFTER_WLAST_MAX(LAW), .B_AFTER_WEND_MAX(LB)) u0 (
    .clk(clk), .rst(rst), .arvalid(arvalid), .arready(arready), .rvalid(rvalid),
    .rready(rready), .rlast(rlast), .awvalid(awvalid), .awready(awready),
    .wvalid(wvalid), .wready(wready), .wlast(wlast), .bvalid(bvalid),
    .bready(bready), .err_flags(f0), .err_pulse(p0));

  axi_gap_watchdog #(.RD_DEPTH(DEP), .WR_DEPTH(DEP), .R_AFTER_AR_MAX(0),
    .W_AFTER_AW_MAX(0), .AW_AFTER_WLAST_MAX(0), .B_AFTER_WEND_MAX(0)) u1 (
    .clk(clk), .rst(rst), .arvalid(arvalid), .arready(arready), .rvalid(rvalid),
    .rready(rready), .rlast(rlast), .awvalid(awvalid), .awready(awready),
    .wvalid(wvalid), .wready(wready), .wlast(wlast), .bvalid(bvalid),
    .bready(bready), .err_flags(f1), .err_pulse(p1));

  always @(posedge clk) begin
    if (rst) pulse_cnt <= 0;
    else if (p0) pulse_cnt <= pulse_cnt + 1;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    {arvalid, arready, rvalid, rready, rlast} = '0;
    {awvalid, awready, wvalid, wready, wlast, bvalid, bready} = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ar();
    arvalid = 1; arready = 1; @(negedge clk); arvalid = 0; arready = 0;
  endtask

  task automatic rb(input logic last);
    rvalid = 1; rready = 1; rlast = last; @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
  endtask

  task automatic aw();
    awvalid = 1; awready = 1; @(negedge clk); awvalid = 0; awready = 0;
  endtask

  task automatic wb(input logic last);
    wvalid = 1; wready = 1; wlast = last; @(negedge clk);
    wvalid = 0; wready = 0; wlast = 0;
  endtask

  task automatic bh();
    bvalid = 1; bready = 1; @(negedge clk); bvalid = 0; bready = 0;
  endtask

  task automatic pair();
    awvalid = 1; awready = 1; wvalid = 1; wready = 1; wlast = 1;
    @(negedge clk);
    {awvalid, awready, wvalid, wready, wlast} = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flags after reset", int'(f0), 0);
    chk("R1 pulse after reset", int'(p0), 0);
  endtask

  task automatic t_read_gap();
    do_reset();
    ar(); idle(LR); rb(1); idle(20);
    chk("R7 no flag after read completed", int'(f0), 0);
    ar(); idle(LR);
    chk("R2 limit idle cycles allowed", int'(f0[0]), 0);
    idle(1);
    chk("R2 one past limit flags", int'(f0[0]), 1);
    chk("R11 pulse on first failure", int'(p0), 1);
    idle(1);
    chk("R11 pulse lasts one cycle", int'(p0), 0);
    rb(1); idle(3);
    chk("R11 flag sticky", int'(f0), 1);
    chk("R11 one pulse total", pulse_cnt, 1);
  endtask

  task automatic t_restart();
    do_reset();
    ar(); idle(LR); rb(0); idle(LR); rb(1); idle(2);
    chk("R6 gaps between beats do not add", int'(f0), 0);
  endtask

  task automatic t_write_gap();
    do_reset();
    aw(); idle(LW); wb(1); bh(); idle(3);
    chk("R3 limit idle cycles allowed", int'(f0), 0);
    aw(); idle(LW + 1);
    chk("R3 one past limit flags", int'(f0[1]), 1);
    chk("R3 response timer quiet", int'(f0[3]), 0);
  endtask

  task automatic t_aw_gap();
    do_reset();
    wb(1); idle(LAW); aw(); bh(); idle(2);
    chk("R4 limit idle cycles allowed", int'(f0), 0);
    wb(1); idle(LAW);
    chk("R4 at limit no flag", int'(f0[2]), 0);
    idle(1);
    chk("R4 one past limit flags", int'(f0[2]), 1);
    chk("R4 data timer quiet", int'(f0[1]), 0);
  endtask

  task automatic t_b_gap();
    do_reset();
    aw(); wb(1); idle(LB); bh(); idle(2);
    chk("R5 limit idle cycles allowed", int'(f0), 0);
    aw(); wb(1); idle(LB);
    chk("R5 at limit no flag", int'(f0[3]), 0);
    idle(1);
    chk("R5 one past limit flags", int'(f0[3]), 1);
  endtask

  task automatic t_rd_ovf();
    do_reset();
    repeat (DEP) ar();
    chk("R8 full tracker no overflow", int'(f0[4]), 0);
    ar();
    chk("R8 push while full flags", int'(f0[4]), 1);
    chk("R8 read timer quiet", int'(f0[0]), 0);
  endtask

  task automatic t_wr_ovf();
    do_reset();
    repeat (DEP) pair();
    bh(); pair();
    chk("R9 response frees entry", int'(f0[5]), 0);
    pair();
    chk("R9 completion while full flags", int'(f0[5]), 1);
    chk("R9 response timer quiet", int'(f0[3]), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    ar(); aw(); idle(40);
    wb(1); wb(1); idle(40);
    chk("R10 zero limits stay silent", int'(f1[3:0]), 0);
    chk("R10 zero limits pulse", int'(p1), 0);
    chk("R10 nonzero limits all fire", int'(f0[3:0]), 15);
    chk("R11 later failures no pulse", pulse_cnt, 1);
    do_reset();
    chk("R1 reset clears sticky flags", int'(f0), 0);
  endtask

  initial begin
    t_reset();
    t_read_gap();
    t_restart();
    t_write_gap();
    t_aw_gap();
    t_b_gap();
    t_rd_ovf();
    t_wr_ovf();
    t_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule